// File: doc/BRIEF.md
# Lookup-Table Phase Correlator

The block runs a closed excitation-and-measure loop from one 256-word table. A 32-bit phase register advances by a programmable increment on every active clock. Its top eight bits select a table word. The two low bytes of that word go straight out as a pair of DAC stimulus codes. The two high bytes are signed reference values, one in-phase and one quadrature. Both are multiplied by a single ADC feedback bit, taken as +1 or -1, and each product is summed into its own saturating accumulator.

After a chosen number of active clocks the accumulated pair gives a point whose angle and magnitude describe the response of the system under test. Software loads the table while the block is idle. It then clears the block, sets the sample count and raises the run enable. The result is read once the done flag rises.

Top module: `lut_correlator`

## Requirements
- R1: After reset both accumulators read zero, the phase is zero so the DAC outputs show table entry 0, and done reads as (0 >= sampleTarget).
- R2: On each active clock (runEn high, clearReq low, done low) the phase grows by phaseInc, wrapping modulo 2^32. The table entry shown is the one indexed by phase bits [31:24].
- R3: dacHi always equals bits [15:8] of the addressed table word, and dacLo always equals bits [7:0].
- R4: On an active clock, accX gains the signed value of word bits [31:24] and accY gains the signed value of word bits [23:16] when adcBit is 1. Both values are subtracted when adcBit is 0.
- R5: Each accumulator saturates at the most positive and the most negative ACC_W-bit signed value and never wraps.
- R6: A high clearReq zeros both accumulators, the phase and the sample count at the next edge, and it overrides runEn.
- R7: While runEn is low, the accumulators and the phase hold their values.
- R8: done is high when the count of active clocks since the last clear or reset is at least sampleTarget. While done is high, the accumulators and the phase hold.
- R9: A table write requested while runEn is high is dropped.
- R10: A table write made while runEn is low shows on the outputs from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clearReq | input | 1 | Zero the accumulators, phase and count |
| runEn | input | 1 | Enable stepping and accumulation |
| phaseInc | input | 32 | Phase increment per active clock |
| sampleTarget | input | CNT_W | Number of active clocks before done |
| adcBit | input | 1 | Feedback bit (1 = +1, 0 = -1) |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | 8 | Table write index |
| tblWrData | input | 32 | Table write word |
| dacHi | output | 8 | Stimulus code, word bits [15:8] |
| dacLo | output | 8 | Stimulus code, word bits [7:0] |
| accX | output | ACC_W | In-phase sum |
| accY | output | ACC_W | Quadrature sum |
| done | output | 1 | Sample count reached |

## Verification
The bench drives both saturation rails with the extreme reference values +127 and -128. A design that wraps would flip sign at the rail, and one that mishandles the -128 negation would sum the wrong magnitude. It uses a fractional increment so that each table entry is held for two clocks, which shows a design that indexes the table with the wrong phase bits. A short sample target checks that stepping stops exactly on count, where an off-by-one design runs one clock too many or too few. A write during a run checks that a single-port table ignores it, where a careless design would corrupt the live entry.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef struct packed {
    logic step;
    logic clear;
    logic tblWe;
  } corr_ctrl_t;
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             runEn,
  input  logic             tblWrEn,
  input  logic [CNT_W-1:0] sampleTarget,
  output corr_ctrl_t       ctrl,
  output logic             done
);
  logic [CNT_W-1:0] cntQ;

  assign done       = (cntQ >= sampleTarget);
  assign ctrl.clear = clearReq;
  assign ctrl.step  = runEn && !clearReq && !done;
  assign ctrl.tblWe = tblWrEn && !runEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (ctrl.clear) cntQ <= '0;
    else if (ctrl.step)  cntQ <= cntQ + 1'b1;
  end
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int ACC_W   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  corr_ctrl_t              ctrl,
  input  logic [PHASE_W-1:0]      phaseInc,
  input  logic                    adcBit,
  input  logic [ADDR_W-1:0]       tblWrAddr,
  input  logic [31:0]             tblWrData,
  output logic [7:0]              dacHi,
  output logic [7:0]              dacLo,
  output logic [ACC_W-1:0]        accX,
  output logic [ACC_W-1:0]        accY
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [31:0]        tblMem [DEPTH];
  logic [PHASE_W-1:0] phaseQ;
  logic [31:0]        curWord;
  logic signed [8:0]  refX, refY, addX, addY;
  logic signed [ACC_W-1:0] sumX, sumY;

  function automatic logic signed [ACC_W-1:0] satAdd(
    input logic signed [ACC_W-1:0] a,
    input logic signed [8:0]       d
  );
    logic signed [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {{(ACC_W-8){d[8]}}, d};
    if (s[ACC_W] != s[ACC_W-1])
      satAdd = s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      satAdd = s[ACC_W-1:0];
  endfunction

  assign curWord = tblMem[phaseQ[PHASE_W-1 -: ADDR_W]];
  assign dacHi   = curWord[15:8];
  assign dacLo   = curWord[7:0];
  assign refX    = {curWord[31], curWord[31:24]};
  assign refY    = {curWord[23], curWord[23:16]};
  assign addX    = adcBit ? refX : -refX;
  assign addY    = adcBit ? refY : -refY;
  assign sumX    = satAdd(accX, addX);
  assign sumY    = satAdd(accY, addY);

  always_ff @(posedge clk) begin
    if (ctrl.tblWe) tblMem[tblWrAddr] <= tblWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      accX   <= '0;
      accY   <= '0;
    end else if (ctrl.clear) begin
      phaseQ <= '0;
      accX   <= '0;
      accY   <= '0;
    end else if (ctrl.step) begin
      phaseQ <= phaseQ + phaseInc;
      accX   <= sumX;
      accY   <= sumY;
    end
  end
endmodule

// File: rtl/lut_correlator.sv
module lut_correlator
  import corr_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearReq,
  input  logic             runEn,
  input  logic [31:0]      phaseInc,
  input  logic [CNT_W-1:0] sampleTarget,
  input  logic             adcBit,
  input  logic             tblWrEn,
  input  logic [7:0]       tblWrAddr,
  input  logic [31:0]      tblWrData,
  output logic [7:0]       dacHi,
  output logic [7:0]       dacLo,
  output logic [ACC_W-1:0] accX,
  output logic [ACC_W-1:0] accY,
  output logic             done
);
  corr_ctrl_t ctrl;

  corr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .runEn(runEn),
    .tblWrEn(tblWrEn), .sampleTarget(sampleTarget), .ctrl(ctrl), .done(done)
  );

  corr_datapath #(.PHASE_W(32), .ADDR_W(8), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .phaseInc(phaseInc), .adcBit(adcBit),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData), .dacHi(dacHi), .dacLo(dacLo),
    .accX(accX), .accY(accY)
  );
endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             clearReq,
  input logic             runEn,
  input logic [ACC_W-1:0] accX,
  input logic [ACC_W-1:0] accY,
  input logic             done
);
  logic             prevStep;
  logic [ACC_W-1:0] prevX;
  logic signed [ACC_W:0] dX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStep <= 1'b0;
      prevX    <= '0;
    end else begin
      prevStep <= runEn && !clearReq && !done;
      prevX    <= accX;
    end
  end

  assign dX = $signed({accX[ACC_W-1], accX}) - $signed({prevX[ACC_W-1], prevX});

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (accX == '0 && accY == '0));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !clearReq) |=> ($stable(accX) && $stable(accY)));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !clearReq) |=> ($stable(accX) && $stable(accY)));

  p_step_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    prevStep |-> (dX <= 128 && dX >= -128));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !clearReq && accX == {1'b0, {(ACC_W-1){1'b1}}}) |=> !accX[ACC_W-1]);
endmodule

bind lut_correlator corr_checker #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/tb_lut_correlator.sv
module tb_lut_correlator;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearReq = 1'b0, runEn = 1'b0, adcBit = 1'b0, tblWrEn = 1'b0;
  logic [31:0] phaseInc = '0;
  logic [CW-1:0] sampleTarget = '0;
  logic [7:0] tblWrAddr = '0;
  logic [31:0] tblWrData = '0;
  logic [7:0] dacHi, dacLo;
  logic [AW-1:0] accX, accY;
  logic done;

  int nTests = 0, nFail = 0;
  logic [31:0] mTbl [256];
  logic [31:0] mPhase = '0;
  int mX = 0, mY = 0, mCnt = 0;

  always #2 clk = ~clk;

  lut_correlator #(.ACC_W(AW), .CNT_W(CW)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic cyc(input bit run, input bit clr, input bit adc);
    logic [31:0] w;
    int sx, sy;
    runEn = run; clearReq = clr; adcBit = adc;
    w = mTbl[mPhase[31:24]];
    if (clr) begin
      mPhase = '0; mX = 0; mY = 0; mCnt = 0;
    end else if (run && mCnt < int'(sampleTarget)) begin
      sx = int'($signed(w[31:24])); sy = int'($signed(w[23:16]));
      mX = sat(mX + (adc ? sx : -sx));
      mY = sat(mY + (adc ? sy : -sy));
      mPhase = mPhase + phaseInc;
      mCnt++;
    end
    if (tblWrEn && !run) mTbl[tblWrAddr] = tblWrData;
    @(posedge clk); @(negedge clk);
    tblWrEn = 1'b0; clearReq = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] w;
    w = mTbl[mPhase[31:24]];
    chk({tag, " accX"}, int'($signed(accX)), mX);
    chk({tag, " accY"}, int'($signed(accY)), mY);
    chk({tag, " dacHi R3"}, int'(dacHi), int'(w[15:8]));
    chk({tag, " dacLo R3"}, int'(dacLo), int'(w[7:0]));
    chk({tag, " done R8"}, int'(done), int'(mCnt >= int'(sampleTarget)));
  endtask

  task automatic wr(input int a, input logic [31:0] d, input bit run);
    tblWrEn = 1'b1; tblWrAddr = 8'(a); tblWrData = d;
    cyc(run, 1'b0, 1'b0);
  endtask

  task automatic tReset();
    sampleTarget = 16'd3;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 accX", int'(accX), 0);
    chk("R1 accY", int'(accY), 0);
    chk("R1 done", int'(done), 0);
    for (int i = 0; i < 256; i++)
      wr(i, {8'(i * 37 + 5), 8'(i * 91 + 200), 8'(i ^ 8'h5A), 8'(i)}, 1'b0);
    checkAll("R1 entry0");
    sampleTarget = 16'hFFFF;
  endtask

  task automatic tStep();
    cyc(1'b0, 1'b1, 1'b0);
    phaseInc = 32'h0100_0000;
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b0, 1'(i % 2));
      checkAll("R2 R4 whole");
    end
    phaseInc = 32'h0080_0000;
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b0, 1'(i % 3 == 0));
      checkAll("R2 R4 half");
    end
    phaseInc = 32'hFD00_0000;
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b0, 1'b1);
      checkAll("R2 wrap");
    end
  endtask

  task automatic tHold();
    repeat (3) cyc(1'b0, 1'b0, 1'b1);
    checkAll("R7 idle");
  endtask

  task automatic tClear();
    cyc(1'b1, 1'b1, 1'b1);
    checkAll("R6 clear");
    chk("R6 accX zero", int'(accX), 0);
  endtask

  task automatic tTarget();
    sampleTarget = 16'd5;
    phaseInc = 32'h0300_0000;
    cyc(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 1'b1);
      checkAll("R8 target");
    end
    chk("R8 done high", int'(done), 1);
    sampleTarget = 16'hFFFF;
  endtask

  task automatic tWrite();
    logic [7:0] a;
    phaseInc = '0;
    a = mPhase[31:24];
    wr(int'(a), 32'h0000_A5C3, 1'b1);
    checkAll("R9 blocked");
    wr(int'(a), 32'h0101_A5C3, 1'b0);
    chk("R10 dacHi", int'(dacHi), 32'hA5);
    chk("R10 dacLo", int'(dacLo), 32'hC3);
  endtask

  task automatic tSat();
    wr(0, 32'h7F80_1234, 1'b0);
    phaseInc = '0;
    cyc(1'b0, 1'b1, 1'b0);
    repeat (300) cyc(1'b1, 1'b0, 1'b1);
    chk("R5 max X", int'($signed(accX)), 32767);
    chk("R5 min Y", int'($signed(accY)), -32768);
    checkAll("R5 rail");
    repeat (600) cyc(1'b1, 1'b0, 1'b0);
    chk("R5 min X", int'($signed(accX)), -32768);
    chk("R5 max Y", int'($signed(accY)), 32767);
    checkAll("R5 back");
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    tReset();
    tStep();
    tHold();
    tClear();
    tTarget();
    tWrite();
    tSat();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule